// File: doc/BRIEF.md
# Configuration Memory Checksum Engine

This block computes a 16-bit checksum over a run of bytes in a byte-addressed configuration memory. A single `start` pulse supplies a first address and a byte count. The engine then reads the bytes one at a time through a synchronous read port. It pairs neighbouring bytes into big-endian 16-bit words. Each word is folded into a running value by a nibble-based CRC-16 update. The word window advances by one byte per step, so consecutive words share a byte. When the count is odd, one extra update handles the last byte on its own.

When the run ends, the result is held on `crc_out` and `done` pulses for one cycle. If write-back was requested at start, the engine first stores the result in memory as two bytes, high byte first. A typical use covers 0xF8 bytes starting at address 0x00 and stores the result at 0xFC.

The memory read port has a fixed latency of one cycle and exerts no back-pressure. The engine issues at most one read per cycle and consumes each returned byte in the cycle it arrives. The write port is also fire-and-forget: each write is a single `wr_en` cycle. `start` is a plain control pulse and has no handshake. A `start` that arrives while `busy` is high is dropped.

Top module: `nvcrc_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are 0 and `crc_out` is 0xFFFF.
- R2: Each update takes a 16-bit word w and the current value c. Let d = c XOR w, p1 = d[3:0] and p2 = d[7:4] XOR p1. The new value is (c >> 8) XOR (p1 << 3) XOR (p1 << 8) XOR p2 XOR (p2 << 7) XOR (p2 << 12), kept to 16 bits. The running value starts at 0xFFFF on every accepted start.
- R3: Let E be the count rounded down to even. For i = 0 to E-1 in rising order, the word {mem[a+i], mem[a+i+1]} is folded in, where a is the start address. The byte at the lower address is bits 15:8.
- R4: When the count is odd, one final update uses the word {mem[a+E], 8'h00}.
- R5: With a count of 0, no read is issued and the result is 0xFFFF.
- R6: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` is high for exactly one cycle per run.
- R7: A `start` that arrives while `busy` is high does not change that run's reads, writes or result.
- R8: With write-back enabled, exactly two writes occur before `done`. The first writes `crc_out[15:8]` to the write-back address. The second, in the next cycle, writes `crc_out[7:0]` to that address plus 1. With write-back disabled, `wr_en` stays low.
- R9: After `done`, `crc_out` holds its value until the next accepted start.
- R10: A run with a nonzero count issues exactly E+1 reads, to a, a+1, …, a+E in that order. Addresses wrap modulo 2^ADDR_W. Read data is taken one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while busy |
| start_addr | input | ADDR_W | First byte address of the run |
| byte_count | input | CNT_W | Number of bytes covered |
| wb_en | input | 1 | Store the result in memory when the run ends |
| wb_addr | input | ADDR_W | Address of the high result byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| crc_out | output | 16 | Running value; final result after done |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write data |

## Verification
The bench builds the engine with ADDR_W = 8 and CNT_W = 9, so the whole memory fits in a 256-byte model. This setting lets runs start near the top of the address space and wrap past 0xFF. It also allows counts as long as the typical 0xF8-byte header, and places that header's result bytes at 0xFC/0xFD inside the model. Counts of 0, 1, 2 and 3 cover the empty run, the tail-only run and the shortest word runs. A second start is also injected partway through a run.

// File: rtl/nvcrc_pkg.sv
package nvcrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_TAIL,
    ST_WB_HI,
    ST_WB_LO,
    ST_FIN
  } nvcrc_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/nvcrc_fold.sv
// One step of the nibble-folding checksum update (combinational).
module nvcrc_fold (
  input  logic [15:0] crc_q,
  input  logic [15:0] word_in,
  output logic [15:0] crc_d
);
  logic [15:0] diff;
  logic [3:0]  lo_nib;
  logic [3:0]  hi_nib;

  always_comb begin
    diff   = crc_q ^ word_in;
    lo_nib = diff[3:0];
    hi_nib = diff[7:4] ^ lo_nib;
    crc_d  = {8'h00, crc_q[15:8]}
           ^ {9'b0, lo_nib, 3'b0}
           ^ {4'b0, lo_nib, 8'b0}
           ^ {12'b0, hi_nib}
           ^ {5'b0, hi_nib, 7'b0}
           ^ {hi_nib, 12'b0};
  end
endmodule

// File: rtl/nvcrc_seq.sv
// Run sequencer: read issue, consume strobes, write-back and done.
module nvcrc_seq #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  output logic              busy,
  output logic              done,
  output logic              seed_en,
  output logic              cap_en,
  output logic              upd_en,
  output logic              upd_tail,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic              wr_hi,
  output logic [ADDR_W-1:0] wr_addr
);
  import nvcrc_pkg::*;

  nvcrc_state_e      st_q, st_d;
  logic [ADDR_W-1:0] base_q, wba_q;
  logic [CNT_W-1:0]  last_q, iss_q, vidx_q;
  logic              odd_q, wb_q, iss_done_q, vld_q;
  logic              last_byte;

  assign rd_en     = (st_q == ST_FETCH) && !iss_done_q;
  assign rd_addr   = base_q + iss_q[ADDR_W-1:0];
  assign cap_en    = (st_q == ST_FETCH) && vld_q;
  assign last_byte = cap_en && (vidx_q == last_q);
  assign upd_tail  = (st_q == ST_TAIL);
  assign upd_en    = (cap_en && (vidx_q != '0)) || upd_tail;
  assign seed_en   = (st_q == ST_IDLE) && start;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign wr_en     = (st_q == ST_WB_HI) || (st_q == ST_WB_LO);
  assign wr_hi     = (st_q == ST_WB_HI);
  assign wr_addr   = wr_hi ? wba_q : wba_q + 1'b1;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (byte_count == '0) st_d = wb_en ? ST_WB_HI : ST_FIN;
        else                  st_d = ST_FETCH;
      end
      ST_FETCH: if (last_byte) begin
        if (odd_q)     st_d = ST_TAIL;
        else if (wb_q) st_d = ST_WB_HI;
        else           st_d = ST_FIN;
      end
      ST_TAIL:  st_d = wb_q ? ST_WB_HI : ST_FIN;
      ST_WB_HI: st_d = ST_WB_LO;
      ST_WB_LO: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      base_q     <= '0;
      wba_q      <= '0;
      last_q     <= '0;
      iss_q      <= '0;
      vidx_q     <= '0;
      odd_q      <= 1'b0;
      wb_q       <= 1'b0;
      iss_done_q <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      st_q   <= st_d;
      vld_q  <= rd_en;
      vidx_q <= iss_q;
      if (seed_en) begin
        base_q     <= start_addr;
        last_q     <= {byte_count[CNT_W-1:1], 1'b0};
        odd_q      <= byte_count[0];
        wb_q       <= wb_en;
        wba_q      <= wb_addr;
        iss_q      <= '0;
        iss_done_q <= 1'b0;
      end else if (rd_en) begin
        iss_q <= iss_q + 1'b1;
        if (iss_q == last_q) iss_done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvcrc_engine.sv
// Top: sequencer plus checksum register and previous-byte register.
module nvcrc_engine #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  output logic              busy,
  output logic              done,
  output logic [15:0]       crc_out,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  import nvcrc_pkg::*;

  logic        seed_en, cap_en, upd_en, upd_tail, wr_hi;
  logic [15:0] crc_q, crc_d, word;
  logic [7:0]  prev_q;

  nvcrc_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .wb_en(wb_en), .wb_addr(wb_addr),
    .busy(busy), .done(done), .seed_en(seed_en), .cap_en(cap_en),
    .upd_en(upd_en), .upd_tail(upd_tail), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_addr(wr_addr)
  );

  assign word = upd_tail ? {prev_q, 8'h00} : {prev_q, rd_data};

  nvcrc_fold u_fold (.crc_q(crc_q), .word_in(word), .crc_d(crc_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= CRC_SEED;
      prev_q <= '0;
    end else begin
      if (seed_en)     crc_q <= CRC_SEED;
      else if (upd_en) crc_q <= crc_d;
      if (cap_en) prev_q <= rd_data;
    end
  end

  assign crc_out = crc_q;
  assign wr_data = wr_hi ? crc_q[15:8] : crc_q[7:0];
endmodule

// File: rtl/nvcrc_engine_chk.sv
module nvcrc_engine_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [15:0]       crc_out,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc_out)); // R9
  AST_READ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy); // R10
  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && !done)); // R8
  AST_WB_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> (wr_data == crc_out[15:8])); // R8
  AST_WB_LOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |->
      ((wr_addr == $past(wr_addr) + 1'b1) && (wr_data == crc_out[7:0]))); // R8
  AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |=> wr_en); // R8
endmodule

bind nvcrc_engine nvcrc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .crc_out(crc_out), .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/nvcrc_engine_test.sv
module nvcrc_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 9;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          wb_en = 1'b0;
  logic [AW-1:0] wb_addr = '0;
  logic          busy, done, rd_en, wr_en;
  logic [15:0]   crc_out;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;

  logic [7:0] mem [0:255];

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rd_cnt, rd_order_bad, done_cnt, busy_gap, wr_cnt;
  logic [AW-1:0] exp_rd_addr;
  logic [AW-1:0] wr_a [0:1];
  logic [7:0]    wr_d [0:1];
  logic          in_run = 1'b0;

  nvcrc_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .wb_en(wb_en), .wb_addr(wb_addr),
    .busy(busy), .done(done), .crc_out(crc_out), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always @(negedge clk) begin
    cyc++;
    if (rd_en) begin
      if (rd_addr != exp_rd_addr) rd_order_bad++;
      exp_rd_addr = exp_rd_addr + 1'b1;
      rd_cnt++;
    end
    if (done) done_cnt++;
    if (in_run && !busy) busy_gap++;
    if (wr_en) begin
      if (wr_cnt < 2) begin
        wr_a[wr_cnt] = wr_addr;
        wr_d[wr_cnt] = wr_data;
      end
      wr_cnt++;
    end
  end

  function automatic logic [15:0] upd(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] d, p1, p2;
    d  = c ^ w;
    p1 = {12'b0, d[3:0]};
    p2 = {12'b0, d[7:4]} ^ p1;
    return (c >> 8) ^ (p1 << 3) ^ (p1 << 8) ^ p2 ^ (p2 << 7) ^ (p2 << 12);
  endfunction

  function automatic logic [15:0] ref_crc(input int a, input int cnt);
    logic [15:0] c;
    int e;
    c = 16'hFFFF;
    e = cnt & ~1;
    for (int i = 0; i < e; i++)
      c = upd(c, {mem[(a + i) & 255], mem[(a + i + 1) & 255]});
    if (cnt % 2 == 1) c = upd(c, {mem[(a + e) & 255], 8'h00});
    return c;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // intr > 0: pulse a conflicting start that many cycles into the run
  task automatic do_run(input int a, input int cnt, input bit wbe, input int wba,
                        input int intr, input string crc_req);
    logic [15:0] exp;
    int e, waited;
    exp = ref_crc(a, cnt);
    e = cnt & ~1;
    @(negedge clk);
    rd_cnt = 0; rd_order_bad = 0; done_cnt = 0; busy_gap = 0; wr_cnt = 0;
    exp_rd_addr = AW'(a);
    start = 1'b1; start_addr = AW'(a); byte_count = CW'(cnt);
    wb_en = wbe; wb_addr = AW'(wba);
    @(negedge clk);
    start = 1'b0;
    in_run = 1'b1;
    waited = 0;
    while (!done) begin
      if (intr > 0 && waited == intr) begin
        start = 1'b1; start_addr = AW'(a + 7); byte_count = CW'(0);
        wb_en = 1'b1; wb_addr = AW'(wba + 3);
      end else start = 1'b0;
      @(negedge clk);
      waited++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected done", cyc);
        finish_up();
      end
    end
    start = 1'b0;
    in_run = 1'b0;
    check(crc_req, "result", crc_out, exp);
    @(negedge clk);
    check("R6", "done pulses", done_cnt, 1);
    check("R6", "busy low during run", busy_gap, 0);
    check("R10", "read count", rd_cnt, (cnt == 0) ? 0 : e + 1);
    check("R10", "read order", rd_order_bad, 0);
    check("R8", "write count", wr_cnt, wbe ? 2 : 0);
    if (wbe) begin
      check("R8", "high byte addr", wr_a[0], wba & 255);
      check("R8", "high byte data", wr_d[0], exp[15:8]);
      check("R8", "low byte addr", wr_a[1], (wba + 1) & 255);
      check("R8", "low byte data", wr_d[1], exp[7:0]);
    end
  endtask

  initial begin
    int seed_dummy;
    logic [15:0] held;
    seed_dummy = $urandom(32'h5EED_0017);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "rd_en after reset", rd_en, 0);
    check("R1", "wr_en after reset", wr_en, 0);
    check("R1", "crc after reset", crc_out, 16'hFFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // typical header run with write-back
    do_run(8'h00, 8'hF8, 1'b1, 8'hFC, 0, "R3");
    check("R8", "memory high byte", mem[8'hFC], ref_crc(0, 8'hF8) >> 8);
    // empty, tail-only and short runs
    do_run(8'h40, 0, 1'b0, 0, 0, "R5");
    check("R5", "empty result", crc_out, 16'hFFFF);
    do_run(8'h41, 1, 1'b0, 0, 0, "R4");
    do_run(8'h42, 2, 1'b0, 0, 0, "R2");
    do_run(8'h43, 3, 1'b1, 8'h10, 0, "R4");
    // address wrap
    do_run(8'hFE, 5, 1'b0, 0, 0, "R10");
    do_run(8'hF9, 12, 1'b0, 0, 0, "R3");
    // start while busy
    do_run(8'h20, 16, 1'b0, 8'h80, 4, "R7");
    do_run(8'h20, 9, 1'b0, 8'h80, 11, "R7");
    // result hold
    held = crc_out;
    repeat (6) @(negedge clk);
    check("R9", "held result", crc_out, held);
    // random runs
    for (int k = 0; k < 24; k++) begin
      int a, c, wba;
      bit w;
      a   = $urandom_range(0, 255);
      c   = $urandom_range(0, 40);
      w   = 1'($urandom);
      wba = $urandom_range(0, 255);
      // keep write-back clear of the bytes being summed
      if (((wba - a) & 255) <= c + 1 || ((wba + 1 - a) & 255) <= c + 1) w = 1'b0;
      do_run(a, c, w, wba, 0, (c % 2 == 1) ? "R4" : "R3");
    end
    finish_up();
  end
endmodule